// File: doc/BRIEF.md
# Macro Call Parameter Collector

This block watches a stream of command-method writes, each made of a method index, a 32-bit argument and a flag that marks the last write of a burst. Writes with an index at or above the macro region base are macro calls, not register writes. A macro call opens with a write to an even index, which names the macro. Its arguments then arrive on the odd index that follows it. Every argument, including the one carried by the opening write, goes into a parameter FIFO. When the last write of the burst arrives, the block launches the macro. The launch carries a start offset, read from a bind table with ((index − base) >> 1) modulo the table size, and the number of arguments collected. The interpreter downstream reads the arguments through the FIFO read port.

Below the macro region, four configuration methods manage the macro code and the bind table. One sets the code upload pointer and requests a clear of code at that address. One writes a code word at the upload pointer and advances the pointer. One sets the bind-entry pointer. One stores a start offset at the bind-entry pointer and advances that pointer. Code memory and the macro interpreter sit outside this block.

The controller has two named states. `S_IDLE` waits for a macro start or a configuration write. `S_COLLECT` accepts arguments for the pending macro. The transitions are:

- START_OPEN: from `S_IDLE` to `S_COLLECT`, on an even macro write without the last flag.
- START_FIRE: stays in `S_IDLE`, on an even macro write with the last flag, which launches at once.
- ARG_HOLD: stays in `S_COLLECT`, on an argument write without the last flag.
- ARG_FIRE: from `S_COLLECT` to `S_IDLE`, on an argument write with the last flag.
- BAD_WRITE: leaves the state unchanged, on any error write.

Top module: `macro_call_collector`

## Requirements
- R1: A write with method index ≥ 0xE00 never causes a code clear, a code write, or a change to the upload or bind pointers.
- R2: In `S_IDLE`, a macro write to an odd index raises `seq_err` for one cycle. It stores no argument and launches nothing.
- R3: In `S_COLLECT`, a write to any index other than the pending macro index plus one raises `seq_err` for one cycle. The write is dropped, and collection continues.
- R4: All accepted arguments enter the FIFO in arrival order, starting with the opening write's argument. `launch_valid` pulses one cycle after the write that carries `mth_last`, and only then. `launch_cnt` equals the number of arguments stored.
- R5: `launch_start` is bind entry `((idx − 0xE00) >> 1) mod 128`. For example, 0xF00 selects entry 0 and 0xFFE selects entry 127.
- R6: A write to method 0x047 sets the bind-entry pointer to `arg[6:0]`. Each write to method 0x048 stores `arg` at that pointer and then increments the pointer.
- R7: A write to method 0x045 loads the upload pointer from `arg`. One cycle later it pulses `code_clr` with `code_addr` = `arg`. Each write to method 0x046 pulses `code_we` one cycle later, with `code_addr` set to the upload pointer and `code_data` set to `arg`, and then increments the pointer.
- R8: After a launch the block is back in `S_IDLE`. The next macro start flushes any unread FIFO contents, and its count starts from zero.
- R9: The FIFO holds 64 arguments. Further arguments of the same macro are dropped, `launch_cnt` stops at 64, and `arg_ovf` is set. `arg_ovf` stays set until reset.
- R10: After reset, all pulse outputs and `arg_ovf` are low, the FIFO is empty, and both pointers and all bind entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mth_valid | input | 1 | A method write is presented |
| mth_idx | input | 13 | Method index |
| mth_arg | input | 32 | Method argument |
| mth_last | input | 1 | Last write of the burst |
| prm_rd | input | 1 | Pop one argument from the FIFO |
| prm_data | output | 32 | Argument at the FIFO head |
| prm_empty | output | 1 | FIFO holds no argument |
| launch_valid | output | 1 | One-cycle macro launch pulse |
| launch_start | output | 32 | Start offset from the bind table |
| launch_cnt | output | 7 | Number of arguments for the launch |
| seq_err | output | 1 | One-cycle pulse on an illegal method sequence |
| arg_ovf | output | 1 | Sticky flag: an argument was dropped |
| code_clr | output | 1 | One-cycle pulse: clear code at `code_addr` |
| code_we | output | 1 | One-cycle pulse: write `code_data` at `code_addr` |
| code_addr | output | 12 | Code memory address |
| code_data | output | 32 | Code word to write |

## Verification
Several rules are checked on every cycle:

- A macro-region write never touches the code port.
- An odd opening write always produces an error and never a launch.
- An illegal write during collection always produces an error.
- A launch always finds the controller idle, with a count between 1 and 64.
- The overflow flag never drops.
- The FIFO never grows past its depth.
- Each bind or upload data write steps its pointer by one.

Some behaviour can only be shown by the bench scenarios, because it depends on data written earlier. These are the modulo lookup into bind entries loaded earlier, the argument order seen at the read port, the flush of unread arguments on a new start, and the saturation of the count at exactly 64 during a 70-argument burst.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [0:0] {
        S_IDLE    = 1'b0,
        S_COLLECT = 1'b1
    } mc_state_e;
endpackage

// File: rtl/mc_param_fifo.sv
module mc_param_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [AW:0]       count;
    logic              do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign rd_data = mem[rptr];
    assign do_wr   = wr_en && (flush || !full);
    assign do_rd   = rd_en && !empty && !flush;

    always_ff @(posedge clk) begin
        if (do_wr) mem[flush ? '0 : wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            rptr  <= '0;
            wptr  <= do_wr ? AW'(1) : '0;
            count <= do_wr ? (AW+1)'(1) : '0;
        end else begin
            if (do_wr) wptr <= wptr + AW'(1);
            if (do_rd) rptr <= rptr + AW'(1);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end

    // R9: a push into a full FIFO without a pop or flush leaves it full
    assert_fifo_hold_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush) |=> full);
    // R9: occupancy never exceeds the depth
    assert_fifo_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/mc_bind_table.sv
module mc_bind_table #(
    parameter int ENTRIES = 128,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_we,
    input  logic [$clog2(ENTRIES)-1:0] sel_val,
    input  logic                       bind_we,
    input  logic [DATA_W-1:0]          bind_data,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int EW = $clog2(ENTRIES);

    logic [DATA_W-1:0] tbl [ENTRIES];
    logic [EW-1:0]     ent_ptr;

    assign rd_data = tbl[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_ptr <= '0;
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (bind_we) begin
            tbl[ent_ptr] <= bind_data;
            ent_ptr      <= ent_ptr + EW'(1);
        end else if (sel_we) begin
            ent_ptr <= sel_val;
        end
    end

    // R6: each bind store advances the entry pointer by one
    assert_bind_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bind_we |=> ent_ptr == $past(ent_ptr) + EW'(1));
endmodule

// File: rtl/mc_upload_ptr.sv
module mc_upload_ptr #(
    parameter int CODE_AW = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_we,
    input  logic               data_we,
    input  logic [DATA_W-1:0]  arg,
    output logic               code_clr,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [DATA_W-1:0]  code_data
);
    logic [CODE_AW-1:0] upl_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upl_ptr   <= '0;
            code_clr  <= 1'b0;
            code_we   <= 1'b0;
            code_addr <= '0;
            code_data <= '0;
        end else begin
            code_clr <= 1'b0;
            code_we  <= 1'b0;
            if (addr_we) begin
                upl_ptr   <= arg[CODE_AW-1:0];
                code_clr  <= 1'b1;
                code_addr <= arg[CODE_AW-1:0];
            end else if (data_we) begin
                code_we   <= 1'b1;
                code_addr <= upl_ptr;
                code_data <= arg;
                upl_ptr   <= upl_ptr + CODE_AW'(1);
            end
        end
    end

    // R7: a code data word advances the upload pointer by one
    assert_upload_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !addr_we) |=> upl_ptr == $past(upl_ptr) + CODE_AW'(1));
endmodule

// File: rtl/macro_call_collector.sv
module macro_call_collector #(
    parameter int              IDX_W         = 13,
    parameter int              DATA_W        = 32,
    parameter logic [12:0]     MACRO_BASE    = 13'hE00,
    parameter int              FIFO_DEPTH    = 64,
    parameter int              BIND_ENTRIES  = 128,
    parameter int              CODE_AW       = 12,
    parameter logic [12:0]     UPL_ADDR_MTH  = 13'h045,
    parameter logic [12:0]     UPL_DATA_MTH  = 13'h046,
    parameter logic [12:0]     BIND_SEL_MTH  = 13'h047,
    parameter logic [12:0]     BIND_DATA_MTH = 13'h048
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mth_valid,
    input  logic [IDX_W-1:0]   mth_idx,
    input  logic [DATA_W-1:0]  mth_arg,
    input  logic               mth_last,
    input  logic               prm_rd,
    output logic [DATA_W-1:0]  prm_data,
    output logic               prm_empty,
    output logic               launch_valid,
    output logic [DATA_W-1:0]  launch_start,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] launch_cnt,
    output logic               seq_err,
    output logic               arg_ovf,
    output logic               code_clr,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [DATA_W-1:0]  code_data
);
    import mc_pkg::*;

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int ENT_W = $clog2(BIND_ENTRIES);

    mc_state_e          state, state_nx;
    logic [IDX_W-1:0]   cur_id;
    logic [CNT_W-1:0]   argcnt;

    logic               is_mac, start_ok, start_bad, arg_ok, arg_bad;
    logic               push, flush, fire, accept, ovf_set, err;
    logic               cfg_ok;
    logic [IDX_W-1:0]   id_eff, id_off;
    logic [ENT_W-1:0]   ent_idx;
    logic [CNT_W-1:0]   cnt_after;
    logic               fifo_full;
    logic [DATA_W-1:0]  tbl_rd;

    // Decode and next state
    always_comb begin
        is_mac    = mth_idx >= IDX_W'(MACRO_BASE);
        start_ok  = 1'b0;
        start_bad = 1'b0;
        arg_ok    = 1'b0;
        arg_bad   = 1'b0;
        cfg_ok    = 1'b0;
        state_nx  = state;
        unique case (state)
            S_IDLE: begin
                start_ok  = mth_valid && is_mac && !mth_idx[0];
                start_bad = mth_valid && is_mac &&  mth_idx[0];
                cfg_ok    = mth_valid && !is_mac;
                if (start_ok && !mth_last) state_nx = S_COLLECT;
            end
            S_COLLECT: begin
                arg_ok  = mth_valid && (mth_idx == cur_id + IDX_W'(1));
                arg_bad = mth_valid && !arg_ok;
                if (arg_ok && mth_last) state_nx = S_IDLE;
            end
        endcase
        push      = start_ok || arg_ok;
        flush     = start_ok;
        fire      = push && mth_last;
        accept    = push && (flush || !fifo_full);
        ovf_set   = push && !flush && fifo_full;
        err       = start_bad || arg_bad;
        id_eff    = (state == S_IDLE) ? mth_idx : cur_id;
        id_off    = id_eff - IDX_W'(MACRO_BASE);
        ent_idx   = id_off[ENT_W:1];
        cnt_after = (flush ? '0 : argcnt) + CNT_W'(accept);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cur_id <= '0;
            argcnt <= '0;
        end else begin
            state <= state_nx;
            if (start_ok) cur_id <= mth_idx;
            if (fire)      argcnt <= '0;
            else if (push) argcnt <= cnt_after;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch_valid <= 1'b0;
            launch_start <= '0;
            launch_cnt   <= '0;
            seq_err      <= 1'b0;
            arg_ovf      <= 1'b0;
        end else begin
            launch_valid <= fire;
            seq_err      <= err;
            arg_ovf      <= arg_ovf || ovf_set;
            if (fire) begin
                launch_start <= tbl_rd;
                launch_cnt   <= cnt_after;
            end
        end
    end

    mc_param_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(accept),
        .wr_data(mth_arg), .rd_en(prm_rd), .rd_data(prm_data),
        .empty(prm_empty), .full(fifo_full)
    );

    mc_bind_table #(.ENTRIES(BIND_ENTRIES), .DATA_W(DATA_W)) u_bind (
        .clk(clk), .rst_n(rst_n),
        .sel_we(cfg_ok && mth_idx == IDX_W'(BIND_SEL_MTH)),
        .sel_val(mth_arg[ENT_W-1:0]),
        .bind_we(cfg_ok && mth_idx == IDX_W'(BIND_DATA_MTH)),
        .bind_data(mth_arg), .rd_idx(ent_idx), .rd_data(tbl_rd)
    );

    mc_upload_ptr #(.CODE_AW(CODE_AW), .DATA_W(DATA_W)) u_upl (
        .clk(clk), .rst_n(rst_n),
        .addr_we(cfg_ok && mth_idx == IDX_W'(UPL_ADDR_MTH)),
        .data_we(cfg_ok && mth_idx == IDX_W'(UPL_DATA_MTH)),
        .arg(mth_arg), .code_clr(code_clr), .code_we(code_we),
        .code_addr(code_addr), .code_data(code_data)
    );

    // R1: macro-region writes never reach the code port
    assert_macro_no_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mth_valid && mth_idx >= IDX_W'(MACRO_BASE)) |=> (!code_we && !code_clr));
    // R2: odd opening write is an error and never launches
    assert_odd_start_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && mth_valid && mth_idx >= IDX_W'(MACRO_BASE) && mth_idx[0])
        |=> (seq_err && !launch_valid));
    // R3: foreign write while collecting is an error
    assert_collect_foreign_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COLLECT && mth_valid && mth_idx != cur_id + IDX_W'(1)) |=> seq_err);
    // R4: a launch carries at least one argument
    assert_launch_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> launch_cnt != '0);
    // R8: after a launch the controller is idle
    assert_launch_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> state == S_IDLE);
    // R9: count saturates at depth, overflow is sticky
    assert_cnt_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        launch_cnt <= CNT_W'(FIFO_DEPTH));
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arg_ovf |=> arg_ovf);
endmodule

// File: tb/tb_macro_call_collector.sv
module tb_macro_call_collector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mth_valid = 1'b0;
    logic [12:0] mth_idx = '0;
    logic [31:0] mth_arg = '0;
    logic        mth_last = 1'b0;
    logic        prm_rd = 1'b0;
    logic [31:0] prm_data;
    logic        prm_empty;
    logic        launch_valid;
    logic [31:0] launch_start;
    logic [6:0]  launch_cnt;
    logic        seq_err, arg_ovf, code_clr, code_we;
    logic [11:0] code_addr;
    logic [31:0] code_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    macro_call_collector dut (
        .clk(clk), .rst_n(rst_n), .mth_valid(mth_valid), .mth_idx(mth_idx),
        .mth_arg(mth_arg), .mth_last(mth_last), .prm_rd(prm_rd),
        .prm_data(prm_data), .prm_empty(prm_empty), .launch_valid(launch_valid),
        .launch_start(launch_start), .launch_cnt(launch_cnt), .seq_err(seq_err),
        .arg_ovf(arg_ovf), .code_clr(code_clr), .code_we(code_we),
        .code_addr(code_addr), .code_data(code_data)
    );

    // {method index, expected start offset} for single-write launches (R5)
    localparam logic [44:0] VEC [0:6] = '{
        {13'hE00, 32'h0000_00A0},
        {13'hE02, 32'h0000_00A1},
        {13'hE06, 32'h0000_00A3},
        {13'hF00, 32'h0000_00A0},
        {13'hF02, 32'h0000_00A1},
        {13'hFFE, 32'h0000_00AF},
        {13'hE04, 32'h0000_00A2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one write for one cycle; on return the registered results are visible
    task automatic send(input logic [12:0] idx, input logic [31:0] arg, input logic last);
        @(negedge clk);
        mth_valid = 1'b1; mth_idx = idx; mth_arg = arg; mth_last = last;
        @(negedge clk);
        mth_valid = 1'b0; mth_last = 1'b0;
    endtask

    task automatic pop(input string tag, input logic [31:0] exp);
        check(tag, prm_data, exp);
        prm_rd = 1'b1;
        @(negedge clk);
        prm_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 launch_valid", 32'(launch_valid), 0);
        check("R10 seq_err", 32'(seq_err), 0);
        check("R10 arg_ovf", 32'(arg_ovf), 0);
        check("R10 prm_empty", 32'(prm_empty), 1);
        check("R10 code_we", 32'(code_we), 0);

        // R7 upload address then two data words
        send(13'h045, 32'h10, 1'b0);
        check("R7 clr", 32'(code_clr), 1);
        check("R7 clr addr", 32'(code_addr), 32'h10);
        send(13'h046, 32'h111, 1'b0);
        check("R7 we", 32'(code_we), 1);
        check("R7 addr0", 32'(code_addr), 32'h10);
        check("R7 data0", code_data, 32'h111);
        send(13'h046, 32'h222, 1'b0);
        check("R7 addr1", 32'(code_addr), 32'h11);
        check("R7 data1", code_data, 32'h222);

        // R6 load bind entries 0..3 and 127
        send(13'h047, 32'h0, 1'b0);
        for (int k = 0; k < 4; k++) send(13'h048, 32'hA0 + 32'(k), 1'b0);
        send(13'h047, 32'd127, 1'b0);
        send(13'h048, 32'hAF, 1'b0);

        // R1 macro write does not touch code port; R4 two-argument macro
        send(13'hE00, 32'h55, 1'b0);
        check("R1 code_we", 32'(code_we), 0);
        check("R1 code_clr", 32'(code_clr), 0);
        check("R4 no early launch", 32'(launch_valid), 0);
        send(13'hE01, 32'h66, 1'b1);
        check("R4 launch", 32'(launch_valid), 1);
        check("R4 cnt", 32'(launch_cnt), 2);
        check("R6 start e0", launch_start, 32'hA0);
        pop("R4 order0", 32'h55);
        pop("R4 order1", 32'h66);

        // R5 modulo bind lookup table walk
        for (int i = 0; i < 7; i++) begin
            send(VEC[i][44:32], 32'(i), 1'b1);
            check("R5 launch", 32'(launch_valid), 1);
            check("R5 start", launch_start, VEC[i][31:0]);
            check("R5 cnt", 32'(launch_cnt), 1);
            pop("R5 arg", 32'(i));
        end

        // R2 odd opening write
        send(13'hE01, 32'h77, 1'b1);
        check("R2 err", 32'(seq_err), 1);
        check("R2 no launch", 32'(launch_valid), 0);
        check("R2 nothing stored", 32'(prm_empty), 1);

        // R3 foreign writes while collecting
        send(13'hE04, 32'h1, 1'b0);
        send(13'hE03, 32'h99, 1'b1);
        check("R3 err wrong idx", 32'(seq_err), 1);
        check("R3 no launch", 32'(launch_valid), 0);
        send(13'h046, 32'h98, 1'b0);
        check("R3 err cfg", 32'(seq_err), 1);
        check("R3 cfg dropped", 32'(code_we), 0);
        send(13'hE05, 32'h2, 1'b1);
        check("R3 launch", 32'(launch_valid), 1);
        check("R3 cnt", 32'(launch_cnt), 2);
        check("R3 start", launch_start, 32'hA2);
        pop("R3 arg0", 32'h1);
        pop("R3 arg1", 32'h2);

        // R8 unread arguments flushed by next start
        send(13'hE06, 32'h5, 1'b0);
        send(13'hE07, 32'h6, 1'b1);
        send(13'hE02, 32'h7, 1'b1);
        check("R8 cnt fresh", 32'(launch_cnt), 1);
        check("R8 start", launch_start, 32'hA1);
        pop("R8 head", 32'h7);
        check("R8 empty", 32'(prm_empty), 1);

        // R9 overflow: 70 arguments into a 64-entry FIFO
        send(13'hE00, 32'h0, 1'b0);
        for (int k = 1; k < 70; k++) send(13'hE01, 32'(k), (k == 69));
        check("R9 launch", 32'(launch_valid), 1);
        check("R9 cnt sat", 32'(launch_cnt), 64);
        check("R9 ovf", 32'(arg_ovf), 1);
        for (int k = 0; k < 64; k++) pop("R9 order", 32'(k));
        check("R9 empty", 32'(prm_empty), 1);
        send(13'hE02, 32'h3, 1'b1);
        check("R9 ovf sticky", 32'(arg_ovf), 1);
        check("R9 next cnt", 32'(launch_cnt), 1);

        finish_run();
    end
endmodule